// File: doc/BRIEF.md
# Output-Encoded Road Junction Light Controller

This block sequences the lamps at a junction of a busy main road and a lightly used side road. The main road keeps green until a car waits on the side road and a long interval has elapsed. Control then passes through main yellow, side green and side yellow, and returns to main green. The side road keeps green only while cars keep arriving and the long interval has not run out.

The controller has no separate state flip-flops. The two registered two-bit lamp codes are the whole state. Each phase shows a lamp pattern that no other phase shows, so the next-state logic decodes the four lamp bits directly.

A combinational start pulse goes high in every cycle whose next clock edge changes the phase. That pulse clears an internal interval counter. The counter raises a short flag after a parameterised number of cycles and a long flag after a larger number. Both flags stay high until the next phase change.

Top module: `tlc_out_enc_ctrl`

## Requirements
- R1: While reset is asserted and the sensor is 0, the main lamp shows green (00), the side lamp shows red (10), and the start pulse is 0.
- R2: In main green (main 00, side 10), the lamps hold unless the sensor is 1 and the long flag is set. In that case the start pulse is 1 and the next edge shows main yellow (main 01, side 10).
- R3: In main yellow, the lamps hold until the short flag is set. Then the start pulse is 1 and the next edge shows side green (main 10, side 00).
- R4: In side green, the lamps hold while the sensor is 1 and the long flag is clear. If the sensor is 0 or the long flag is set, the start pulse is 1 and the next edge shows side yellow (main 10, side 01).
- R5: In side yellow, the lamps hold until the short flag is set. Then the start pulse is 1 and the next edge returns to main green.
- R6: Lamp codes are green 00, yellow 01 and red 10. Only the four phase patterns appear, and both lamps are never green together.
- R7: The start pulse is 1 in exactly those cycles after which the lamp pattern changes. It is combinational from the registered lamps, the sensor and the flags.
- R8: The counter clears at each phase change. The short flag is set once SHORT_CYC edges have passed since the change, and the long flag once LONG_CYC edges have passed. Both flags then stay set. As a result, each yellow phase lasts SHORT_CYC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| car_sense | input | 1 | Side-road car present |
| main_lamp | output | 2 | Main-road lamp code |
| side_lamp | output | 2 | Side-road lamp code |
| timer_start | output | 1 | Phase-change pulse that restarts the interval counter |

## Verification
The bench builds the block with SHORT_CYC=3 and LONG_CYC=10. These short intervals let a few thousand cycles pass through every phase many times. Both the long-flag exit and the sensor-drop exit from side green occur, and so do main-green waits that end just as the long flag rises. Random sensor values, held for random run lengths, are mixed with directed stretches of a steady sensor. A cycle-level reference model predicts the lamps and the start pulse in every cycle.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int LAMP_W = 2;
  localparam logic [LAMP_W-1:0] LAMP_GRN = 2'b00;
  localparam logic [LAMP_W-1:0] LAMP_YEL = 2'b01;
  localparam logic [LAMP_W-1:0] LAMP_RED = 2'b10;

  typedef struct packed {
    logic [LAMP_W-1:0] main_l;
    logic [LAMP_W-1:0] side_l;
  } lamps_t;

  localparam lamps_t PH_MAIN_GO   = '{main_l: LAMP_GRN, side_l: LAMP_RED};
  localparam lamps_t PH_MAIN_WARN = '{main_l: LAMP_YEL, side_l: LAMP_RED};
  localparam lamps_t PH_SIDE_GO   = '{main_l: LAMP_RED, side_l: LAMP_GRN};
  localparam lamps_t PH_SIDE_WARN = '{main_l: LAMP_RED, side_l: LAMP_YEL};
endpackage

// File: rtl/tlc_phase_logic.sv
module tlc_phase_logic
  import tlc_pkg::*;
(
  input  lamps_t cur_lamps,
  input  logic   car_sense,
  input  logic   short_done,
  input  logic   long_done,
  output lamps_t nxt_lamps,
  output logic   phase_chg
);
  always_comb begin
    nxt_lamps = PH_MAIN_GO;
    case (cur_lamps)
      PH_MAIN_GO:   nxt_lamps = (car_sense && long_done) ? PH_MAIN_WARN : PH_MAIN_GO;
      PH_MAIN_WARN: nxt_lamps = short_done ? PH_SIDE_GO : PH_MAIN_WARN;
      PH_SIDE_GO:   nxt_lamps = (!car_sense || long_done) ? PH_SIDE_WARN : PH_SIDE_GO;
      PH_SIDE_WARN: nxt_lamps = short_done ? PH_MAIN_GO : PH_SIDE_WARN;
      default:      nxt_lamps = PH_MAIN_GO;
    endcase
  end

  assign phase_chg = (nxt_lamps != cur_lamps);
endmodule

// File: rtl/tlc_lamp_reg.sv
module tlc_lamp_reg
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_en,
  input  lamps_t nxt_lamps,
  output lamps_t cur_lamps
);
  lamps_t lamps_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lamps_q <= PH_MAIN_GO;
    else if (load_en) lamps_q <= nxt_lamps;
  end

  assign cur_lamps = lamps_q;

  p_no_dual_green_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(lamps_q.main_l == LAMP_GRN && lamps_q.side_l == LAMP_GRN));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(lamps_q));
endmodule

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  localparam int CNT_W = $clog2(LONG_CYC + 1);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYC);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = restart || (cnt_q < LONG_LIM);
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign short_done = (cnt_q >= SHORT_LIM);
  assign long_done  = (cnt_q >= LONG_LIM);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  p_flag_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    long_done |-> short_done);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (long_done && !restart) |=> long_done);
endmodule

// File: rtl/tlc_out_enc_ctrl.sv
module tlc_out_enc_ctrl
  import tlc_pkg::*;
#(
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       car_sense,
  output logic [1:0] main_lamp,
  output logic [1:0] side_lamp,
  output logic       timer_start
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  lamps_t cur_lamps, nxt_lamps;
  logic   short_done, long_done, phase_chg;

  tlc_phase_logic u_logic (
    .cur_lamps (cur_lamps),
    .car_sense (car_sense),
    .short_done(short_done),
    .long_done (long_done),
    .nxt_lamps (nxt_lamps),
    .phase_chg (phase_chg)
  );

  tlc_lamp_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_en  (phase_chg),
    .nxt_lamps(nxt_lamps),
    .cur_lamps(cur_lamps)
  );

  tlc_interval_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .restart   (phase_chg),
    .short_done(short_done),
    .long_done (long_done)
  );

  assign main_lamp   = cur_lamps.main_l;
  assign side_lamp   = cur_lamps.side_l;
  assign timer_start = phase_chg;

  p_start_moves_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    timer_start |=> ({main_lamp, side_lamp} != $past({main_lamp, side_lamp})));
  p_main_warn_wait_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cur_lamps == PH_MAIN_WARN && !short_done) |=> (cur_lamps == PH_MAIN_WARN));
  p_side_warn_exit_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cur_lamps == PH_SIDE_WARN && short_done) |=> (cur_lamps == PH_MAIN_GO));
  p_main_go_hold_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cur_lamps == PH_MAIN_GO && !car_sense) |=> (cur_lamps == PH_MAIN_GO));
endmodule

// File: tb/test_tlc_out_enc_ctrl.sv
module test_tlc_out_enc_ctrl;
  localparam int SHORT = 3;
  localparam int LONG  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car = 1'b0;
  logic [1:0] ml, sl;
  logic st;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  tlc_out_enc_ctrl #(.SHORT_CYC(SHORT), .LONG_CYC(LONG)) i_tlc_out_enc_ctrl (
    .clk(clk), .rst_n(rst_n), .car_sense(car),
    .main_lamp(ml), .side_lamp(sl), .timer_start(st)
  );

  // model: 0 main go, 1 main warn, 2 side go, 3 side warn
  int m_ph;
  int m_cnt;
  int warn_len;

  function automatic logic [3:0] pat(int ph);
    case (ph)
      0: return 4'b0010;
      1: return 4'b0110;
      2: return 4'b1000;
      default: return 4'b1001;
    endcase
  endfunction

  function automatic int nxt(int ph, int cnt, logic c);
    bit ts = (cnt >= SHORT);
    bit tl = (cnt >= LONG);
    case (ph)
      0: return (c && tl) ? 1 : 0;
      1: return ts ? 2 : 1;
      2: return (!c || tl) ? 3 : 2;
      default: return ts ? 0 : 3;
    endcase
  endfunction

  function automatic string req_of(int ph);
    case (ph)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // drive c at negedge, check settled outputs, then advance model at posedge
  task automatic step(logic c);
    int np;
    @(negedge clk);
    car = c;
    #1;
    np = nxt(m_ph, m_cnt, c);
    chk({ml, sl} == pat(m_ph), req_of(m_ph), {ml, sl}, pat(m_ph));
    chk(!(ml == 2'b00 && sl == 2'b00) &&
        ({ml, sl} == 4'b0010 || {ml, sl} == 4'b0110 ||
         {ml, sl} == 4'b1000 || {ml, sl} == 4'b1001), "R6", {ml, sl}, pat(m_ph));
    chk(st == (np != m_ph), "R7", st, (np != m_ph));
    if (m_ph == 1 || m_ph == 3) warn_len++;
    if ((m_ph == 1 || m_ph == 3) && np != m_ph) begin
      chk(warn_len == SHORT + 1, "R8", warn_len, SHORT + 1);
      warn_len = 0;
    end
    if (np != m_ph) m_cnt = 0;
    else if (m_cnt < LONG) m_cnt++;
    m_ph = np;
  endtask

  initial begin
    #200000;
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    warn_len = 0;
    car = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk({ml, sl} == 4'b0010, "R1", {ml, sl}, 4'b0010);
    chk(st == 1'b0, "R1", st, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // sensor low long enough that the counter saturates regardless of sync delay
    repeat (LONG + 6) begin
      @(negedge clk);
      #1;
      chk({ml, sl} == 4'b0010 && st == 1'b0, "R1", {ml, sl, st}, 3'b0);
    end
    m_ph = 0;
    m_cnt = LONG;
    // directed: car arrives with long flag set -> immediate change
    step(1'b1);
    // directed: steady car through several full cycles (side go ends on long flag)
    repeat (3 * (2 * LONG + 2 * SHORT + 8)) step(1'b1);
    // directed: no car; side go ends on sensor drop
    repeat (40) step(1'b0);
    // random runs of sensor values
    for (int r = 0; r < 400; r++) begin
      logic c = 1'($urandom_range(0, 1));
      int len = $urandom_range(1, 14);
      for (int k = 0; k < len; k++) step(c);
    end
    // short random flicker
    repeat (500) step(1'($urandom_range(0, 1)));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule